// File: doc/BRIEF.md
# Privilege-Aware Byte-Order Swapper

This block sits between a processor's load/store pipeline and physical memory and fixes the byte order of every data transfer. Each privilege level has its own big-endian control bit. For each access, the block works out which privilege the access really runs at and reads that level's bit. If the bit is set, the block mirrors the bytes of the access. Write data is mirrored on its way to memory. Read data is mirrored on its way back to the core. Instruction fetches are never mirrored.

The effective privilege of a data access can differ from the current privilege. When the modify-privilege control is set, data accesses use the saved previous privilege instead. The datapath is purely combinational. A parameter can add one register stage on the outputs. Access widths of 1, 2, 4 and 8 bytes are supported. Any other width code raises an error flag and the data passes through unchanged.

Top module: `endian_swapper`

## Requirements
- R1: With `REG_OUT`=1, every output is registered. Outputs reflect the inputs of the previous clock edge. While `rst` is high at an edge, `rdata_core`, `wdata_mem` and `width_err` become 0.
- R2: Privilege codes are user = 2'b00, supervisor = 2'b01 and machine = 2'b11. These codes select `be_u`, `be_s` and `be_m` respectively. The unused code 2'b10 selects no swap.
- R3: When `acc_kind` = 2'b00 (instruction fetch), `rdata_core` equals `rdata_mem`, whatever the control bits say.
- R4: The read path uses `mpp` as its privilege when `mprv`=1 and the access is not a fetch. Otherwise it uses `cur_priv`. The write path always judges as a store, so it uses `mpp` whenever `mprv`=1.
- R5: For `acc_kind` 2'b01 (load), 2'b10 (store) or 2'b11 (AMO), read data depends on the selected bit. If the bit is 1, the lowest N bytes of the read data come out in reversed order. If the bit is 0, the data passes unchanged.
- R6: When the write-path bit is 1, the lowest N bytes of `wdata_core` are reversed before they appear on `wdata_mem`. When the bit is 0, `wdata_mem` equals `wdata_core`.
- R7: `width_code` values 0, 1, 2 and 3 mean N = 1, 2, 4 and 8 bytes. Bytes at or above N are never moved. A 1-byte access is always unchanged.
- R8: For `width_code` values 4 to 7, `width_err` is 1 and both data paths pass through unchanged. For all legal codes, `width_err` is 0.
- R9: Suppose a value is written at some width and endianness setting. If the memory-side result is then read back as a load with the same settings, the original value comes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when REG_OUT=1) |
| rst | input | 1 | Synchronous active-high reset |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 AMO |
| width_code | input | 3 | Access size code, N = 2^code bytes |
| cur_priv | input | 2 | Current privilege |
| mprv | input | 1 | Data accesses use saved privilege |
| mpp | input | 2 | Saved previous privilege |
| be_m | input | 1 | Machine big-endian bit |
| be_s | input | 1 | Supervisor big-endian bit |
| be_u | input | 1 | User big-endian bit |
| wdata_core | input | 64 | Store data from the core |
| rdata_mem | input | 64 | Read data from memory |
| wdata_mem | output | 64 | Store data toward memory |
| rdata_core | output | 64 | Read data toward the core |
| width_err | output | 1 | Unsupported width code |

## Verification
The bench drives these input patterns:
- Distinct byte values, such as 0x0102030405060708. A mirror at the wrong width, or on the wrong byte lanes, shows up as a misplaced byte.
- Fetches and loads with every control bit set. These separate "never swap fetch" from "swap load".
- Modify-privilege cases where the current and saved privileges have opposite bits. These show which privilege the block picked, and show that the read and write paths judge differently for a fetch.
- Illegal width codes, to confirm pass-through and the error flag.
- Round trips and a long stream of pseudo-random vectors. These are compared against a behavioural byte-loop model and cover every combination of width, privilege and bit.

// File: rtl/endian_swap_pkg.sv
package endian_swap_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_AMO   = 2'b11
    } acc_kind_e;

    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    localparam logic [1:0] PRIV_MACH  = 2'b11;

    typedef struct packed {
        logic m;
        logic s;
        logic u;
    } be_bits_t;

    // Privilege an access really runs at.
    function automatic logic [1:0] effective_priv(
        input logic       use_saved,
        input logic [1:0] saved,
        input logic [1:0] cur,
        input logic       is_fetch
    );
        return (use_saved && !is_fetch) ? saved : cur;
    endfunction

    // Big-endian control of a privilege; the unused code gives little-endian.
    function automatic logic be_of_priv(input logic [1:0] p, input be_bits_t b);
        logic r;
        case (p)
            PRIV_MACH:  r = b.m;
            PRIV_SUPER: r = b.s;
            PRIV_USER:  r = b.u;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/endian_priv_sel.sv
module endian_priv_sel
    import endian_swap_pkg::*;
(
    input  acc_kind_e  kind,
    input  logic [1:0] cur_priv,
    input  logic       mprv,
    input  logic [1:0] mpp,
    input  be_bits_t   be,
    output logic       rd_swap,
    output logic       wr_swap
);
    logic [1:0] rd_priv;
    logic [1:0] wr_priv;
    logic       is_fetch;

    always_comb begin
        is_fetch = (kind == ACC_FETCH);
        rd_priv  = effective_priv(mprv, mpp, cur_priv, is_fetch);
        // Write path is always judged as a store access.
        wr_priv  = effective_priv(mprv, mpp, cur_priv, 1'b0);
        rd_swap  = !is_fetch && be_of_priv(rd_priv, be);
        wr_swap  = be_of_priv(wr_priv, be);
    end
endmodule

// File: rtl/endian_byte_rev.sv
module endian_byte_rev #(
    parameter int NBYTES  = 8,
    parameter int WCODE_W = 3
) (
    input  logic [NBYTES*8-1:0] din,
    input  logic [WCODE_W-1:0]  wcode,
    input  logic                swap,
    output logic [NBYTES*8-1:0] dout
);
    localparam int SIZES = $clog2(NBYTES) + 1;

    logic [NBYTES*8-1:0] cand [SIZES];

    for (genvar g = 0; g < SIZES; g++) begin : g_size
        localparam int SPAN = 1 << g;
        for (genvar i = 0; i < NBYTES; i++) begin : g_byte
            if (i < SPAN) begin : g_in
                assign cand[g][8*i +: 8] = din[8*(SPAN-1-i) +: 8];
            end else begin : g_out
                assign cand[g][8*i +: 8] = din[8*i +: 8];
            end
        end
    end

    always_comb begin
        dout = din;
        if (swap) begin
            for (int g = 0; g < SIZES; g++) begin
                if (int'(wcode) == g) dout = cand[g];
            end
        end
    end
endmodule

// File: rtl/endian_swapper.sv
module endian_swapper
    import endian_swap_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter int WCODE_W    = 3,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              acc_kind,
    input  logic [WCODE_W-1:0]      width_code,
    input  logic [1:0]              cur_priv,
    input  logic                    mprv,
    input  logic [1:0]              mpp,
    input  logic                    be_m,
    input  logic                    be_s,
    input  logic                    be_u,
    input  logic [DATA_BYTES*8-1:0] wdata_core,
    input  logic [DATA_BYTES*8-1:0] rdata_mem,
    output logic [DATA_BYTES*8-1:0] wdata_mem,
    output logic [DATA_BYTES*8-1:0] rdata_core,
    output logic                    width_err
);
    localparam int DATA_W = DATA_BYTES * 8;
    localparam int SIZES  = $clog2(DATA_BYTES) + 1;

    acc_kind_e          kind;
    be_bits_t           be;
    logic               rd_swap, wr_swap, width_ok;
    logic [DATA_W-1:0]  rd_next, wr_next;

    assign kind     = acc_kind_e'(acc_kind);
    assign be       = '{m: be_m, s: be_s, u: be_u};
    assign width_ok = (int'(width_code) < SIZES);

    endian_priv_sel u_sel (
        .kind     (kind),
        .cur_priv (cur_priv),
        .mprv     (mprv),
        .mpp      (mpp),
        .be       (be),
        .rd_swap  (rd_swap),
        .wr_swap  (wr_swap)
    );

    endian_byte_rev #(.NBYTES(DATA_BYTES), .WCODE_W(WCODE_W)) u_rd_rev (
        .din   (rdata_mem),
        .wcode (width_code),
        .swap  (rd_swap && width_ok),
        .dout  (rd_next)
    );

    endian_byte_rev #(.NBYTES(DATA_BYTES), .WCODE_W(WCODE_W)) u_wr_rev (
        .din   (wdata_core),
        .wcode (width_code),
        .swap  (wr_swap && width_ok),
        .dout  (wr_next)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                rdata_core <= '0;
                wdata_mem  <= '0;
                width_err  <= 1'b0;
            end else begin
                rdata_core <= rd_next;
                wdata_mem  <= wr_next;
                width_err  <= !width_ok;
            end
        end
    end else begin : g_comb
        assign rdata_core = rd_next;
        assign wdata_mem  = wr_next;
        assign width_err  = !width_ok;
    end

    // R3: fetch data reaches the core untouched
    a_r3_fetch_passthru: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == 2'b00) |-> (rd_next == rdata_mem));

    // R7: single-byte access is an identity on both paths
    a_r7_byte_identity: assert property (@(posedge clk) disable iff (rst)
        (width_code == '0) |-> (rd_next == rdata_mem && wr_next == wdata_core));

    // R8: illegal width passes both paths through
    a_r8_bad_width_passthru: assert property (@(posedge clk) disable iff (rst)
        (int'(width_code) >= SIZES) |-> (rd_next == rdata_mem && wr_next == wdata_core));

    // R5: machine big-endian full-width load moves the top byte to the bottom
    a_r5_full_mirror: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == 2'b01 && !mprv && cur_priv == PRIV_MACH && be_m
         && int'(width_code) == SIZES-1)
        |-> (rd_next[7:0] == rdata_mem[DATA_W-1 -: 8]));

    // R1: registered outputs follow the previous cycle's error decision
    if (REG_OUT) begin : g_reg_chk
        a_r1_err_latency: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (width_err == $past(int'(width_code) >= SIZES)));
    end
endmodule

// File: tb/endian_swapper_test.sv
module endian_swapper_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  acc_kind, cur_priv, mpp;
    logic [2:0]  width_code;
    logic        mprv, be_m, be_s, be_u;
    logic [63:0] wdata_core, rdata_mem;
    logic [63:0] wdata_mem, rdata_core;
    logic        width_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [63:0] rd;
        logic [63:0] wr;
        logic        err;
        string       tag;
    } exp_t;
    exp_t pend[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    endian_swapper #(.DATA_BYTES(8), .WCODE_W(3), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .acc_kind(acc_kind), .width_code(width_code),
        .cur_priv(cur_priv), .mprv(mprv), .mpp(mpp),
        .be_m(be_m), .be_s(be_s), .be_u(be_u),
        .wdata_core(wdata_core), .rdata_mem(rdata_mem),
        .wdata_mem(wdata_mem), .rdata_core(rdata_core), .width_err(width_err)
    );

    function automatic logic [63:0] mirror(logic [63:0] d, int n);
        logic [63:0] r = d;
        for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(n-1-i) +: 8];
        return r;
    endfunction

    function automatic logic bit_for(logic [1:0] p);
        if (p == 2'b11) return be_m;
        if (p == 2'b01) return be_s;
        if (p == 2'b00) return be_u;
        return 1'b0;
    endfunction

    task automatic check64(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge and compare one cycle later.
    task automatic apply(string tag, logic [1:0] k, logic [2:0] w, logic [1:0] cp,
                         logic mv, logic [1:0] sp, logic bm, logic bs, logic bu,
                         logic [63:0] wd, logic [63:0] rd);
        exp_t e, got;
        logic [1:0] rp, wp;
        acc_kind = k; width_code = w; cur_priv = cp; mprv = mv; mpp = sp;
        be_m = bm; be_s = bs; be_u = bu; wdata_core = wd; rdata_mem = rd;
        rp = (mv && k != 2'b00) ? sp : cp;
        wp = mv ? sp : cp;
        e.err = (w > 3'd3);
        e.rd  = (!e.err && k != 2'b00 && bit_for(rp)) ? mirror(rd, 1 << w) : rd;
        e.wr  = (!e.err && bit_for(wp)) ? mirror(wd, 1 << w) : wd;
        e.tag = tag;
        pend.push_back(e);
        @(negedge clk);
        got = pend.pop_front();
        check64(got.tag, "rdata_core", rdata_core, got.rd);
        check64(got.tag, "wdata_mem", wdata_mem, got.wr);
        check64(got.tag, "width_err", {63'd0, width_err}, {63'd0, got.err});
    endtask

    localparam logic [63:0] PAT = 64'h0102030405060708;

    initial begin
        logic [63:0] mem_img, orig;
        rst = 1'b1;
        acc_kind = 2'b01; width_code = 3'd3; cur_priv = 2'b11; mprv = 1'b0; mpp = 2'b00;
        be_m = 1'b1; be_s = 1'b1; be_u = 1'b1; wdata_core = PAT; rdata_mem = PAT;
        repeat (3) @(negedge clk);
        check64("R1", "reset rdata_core", rdata_core, 64'd0);
        check64("R1", "reset wdata_mem", wdata_mem, 64'd0);
        check64("R1", "reset width_err", {63'd0, width_err}, 64'd0);
        rst = 1'b0;

        // R5: full-width machine big-endian load
        apply("R5", 2'b01, 3'd3, 2'b11, 0, 2'b00, 1, 0, 0, 64'd0, PAT);
        check64("R5", "explicit mirror", rdata_core, 64'h0807060504030201);
        apply("R5", 2'b11, 3'd2, 2'b01, 0, 2'b00, 0, 1, 0, 64'd0, PAT);
        apply("R5", 2'b01, 3'd3, 2'b11, 0, 2'b00, 0, 1, 1, 64'd0, PAT);
        // R3: fetch with every bit set
        apply("R3", 2'b00, 3'd3, 2'b11, 0, 2'b00, 1, 1, 1, 64'd0, PAT);
        check64("R3", "fetch untouched", rdata_core, PAT);
        // R7: widths 1, 2, 4
        apply("R7", 2'b01, 3'd0, 2'b11, 0, 2'b00, 1, 1, 1, PAT, PAT);
        apply("R7", 2'b01, 3'd1, 2'b11, 0, 2'b00, 1, 1, 1, PAT, PAT);
        check64("R7", "2-byte lanes", rdata_core, 64'h0102030405060807);
        apply("R7", 2'b10, 3'd2, 2'b00, 0, 2'b00, 0, 0, 1, PAT, PAT);
        check64("R7", "4-byte lanes", wdata_mem, 64'h0102030408070605);
        // R8: illegal widths
        for (int w = 4; w < 8; w++)
            apply("R8", 2'b01, 3'(w), 2'b11, 0, 2'b00, 1, 1, 1, PAT, PAT);
        // R4: saved privilege is user (big), current machine (little)
        apply("R4", 2'b01, 3'd3, 2'b11, 1, 2'b00, 0, 0, 1, PAT, PAT);
        check64("R4", "load uses saved", rdata_core, 64'h0807060504030201);
        apply("R4", 2'b00, 3'd3, 2'b11, 1, 2'b00, 0, 0, 1, PAT, PAT);
        check64("R4", "fetch read unswapped", rdata_core, PAT);
        check64("R4", "write judged as store", wdata_mem, 64'h0807060504030201);
        // R2: unused privilege code and per-level selection
        apply("R2", 2'b01, 3'd3, 2'b10, 0, 2'b00, 1, 1, 1, PAT, PAT);
        check64("R2", "code 10 no swap", rdata_core, PAT);
        apply("R2", 2'b01, 3'd3, 2'b01, 0, 2'b00, 1, 0, 1, PAT, PAT);
        // R6: store per privilege
        apply("R6", 2'b10, 3'd3, 2'b01, 0, 2'b00, 0, 1, 0, PAT, 64'd0);
        apply("R6", 2'b10, 3'd3, 2'b00, 0, 2'b00, 1, 1, 0, PAT, 64'd0);
        check64("R6", "user little store", wdata_mem, PAT);
        // R9: round trips at every width
        for (int w = 0; w < 4; w++) begin
            orig = {$urandom, $urandom};
            apply("R9", 2'b10, 3'(w), 2'b01, 0, 2'b00, 0, 1, 0, orig, 64'd0);
            mem_img = wdata_mem;
            apply("R9", 2'b01, 3'(w), 2'b01, 0, 2'b00, 0, 1, 0, 64'd0, mem_img);
            check64("R9", "round trip", rdata_core, orig);
        end
        // Random stream against the model (R5/R6/R4 mixed)
        for (int i = 0; i < 400; i++)
            apply("R5_R6_mix", 2'($urandom), 3'($urandom), 2'($urandom), 1'($urandom),
                  2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  {$urandom, $urandom}, {$urandom, $urandom});
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule